// File: doc/BRIEF.md
# CMI Receive Decoder with Code Violation Flag

This block turns a stream of coded mark inversion (CMI) half-bit samples into NRZ receive data. A clock and data recovery stage upstream delivers one sample per half-bit on `hs_data`, with `hs_en` marking a valid sample. `hs_second` marks the sample that closes a symbol, and it also acts as the recovered bit-clock enable. The decoder classifies each two-sample symbol and keeps the polarity of the last accepted mark. It reports the decoded bit together with a flag that marks a broken coding rule.

Both outputs are registered and change only on a bit strobe, which is a cycle where `hs_en` and `hs_second` are both high. The flag always leaves the block in the same cycle as the bit it describes. A symbol's result appears one bit plus one half-bit after the symbol's first sample, counted in sample strobes. The number of whole bit periods in that delay is set by the parameter `PIPE_BITS`, and its default is 1. A symbol made of two different halves is a space. A symbol made of two equal halves is a mark, and marks must alternate in level.

Top module: `cmi_rx_decoder`

## Requirements
- R1: While reset is held (`rst_n` low) and after it is released, `rx_data` and `rx_viol` are 0, and no mark reference is stored.
- R2: A symbol whose first half is 0 and whose second half is 1 (low then high) decodes as data 0 with `rx_viol` low.
- R3: A symbol whose first half is 1 and whose second half is 0 (high then low) decodes as data 0 with `rx_viol` high.
- R4: A symbol with equal halves (00 or 11) decodes as data 1. The flag is set only if the symbol's level equals the level of the last accepted mark.
- R5: A flagged mark leaves the stored mark reference unchanged.
- R6: The first mark after reset is accepted without a flag, whatever its level, and its level becomes the reference.
- R7: The outputs change only in the cycle after a bit strobe. Idle cycles and first-half strobes (`hs_en` high, `hs_second` low) leave them unchanged.
- R8: With `PIPE_BITS`=1, after bit strobe n the outputs show the data and flag of the symbol that closed at bit strobe n-1. That is 1.5 bits after that symbol's first sample, and the data and flag change together.
- R9: A symbol's first half is the most recent first-half strobe before its bit strobe. Any number of idle cycles may lie between the two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_en | input | 1 | Half-bit sample valid strobe |
| hs_second | input | 1 | Marks the sample as a symbol's second half; acts as the bit-clock enable |
| hs_data | input | 1 | Half-bit sample level, 1 = high |
| rx_data | output | 1 | Decoded NRZ bit |
| rx_viol | output | 1 | Code violation flag, aligned with `rx_data` |

## Verification
The assertions check four things on every cycle:
- Both outputs hold still whenever there is no bit strobe.
- A low-high symbol gives a clean 0 and a high-low symbol gives a flagged 0 at the classification stage.
- An equal-half symbol always decodes as 1.
- The output stage passes on what the classification stage held at the strobe.

The bench scenarios cover what depends on history: whether a mark is flagged against the stored reference, that a flagged mark leaves the reference alone, and how the first mark after a mid-stream reset is treated. They also cover the full 1.5-bit alignment seen at the ports, with random idle gaps placed between strobes.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;

    // Decoded result of one symbol
    typedef struct packed {
        logic data;
        logic viol;
    } bit_res_t;

    // Level of the last accepted mark
    typedef struct packed {
        logic valid;
        logic level;
    } alt_ref_t;

    typedef struct packed {
        alt_ref_t alt;
        bit_res_t res;
    } judge_state_t;

endpackage

// File: rtl/cmi_half_capture.sv
module cmi_half_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic hs_second,
    input  logic hs_data,
    output logic first_half
);

    logic first_d, first_q;

    always_comb begin
        first_d = first_q;
        if (hs_en && !hs_second) begin
            first_d = hs_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else begin
            first_q <= first_d;
        end
    end

    assign first_half = first_q;

endmodule

// File: rtl/cmi_symbol_judge.sv
module cmi_symbol_judge
    import cmi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sym_stb,
    input  logic     first_half,
    input  logic     second_half,
    output bit_res_t res
);

    judge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sym_stb) begin
            unique case ({first_half, second_half})
                2'b01: begin
                    st_d.res.data = 1'b0;
                    st_d.res.viol = 1'b0;
                end
                2'b10: begin
                    st_d.res.data = 1'b0;
                    st_d.res.viol = 1'b1;
                end
                default: begin
                    st_d.res.data = 1'b1;
                    if (st_q.alt.valid && (st_q.alt.level == first_half)) begin
                        st_d.res.viol = 1'b1;
                    end else begin
                        st_d.res.viol  = 1'b0;
                        st_d.alt.valid = 1'b1;
                        st_d.alt.level = first_half;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;

endmodule

// File: rtl/cmi_bit_delay.sv
module cmi_bit_delay
    import cmi_rx_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb,
    input  bit_res_t din,
    output bit_res_t dout
);

    localparam int LAST = STAGES - 1;

    bit_res_t [LAST:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (stb) begin
            pipe_d[0] = din;
            for (int i = 1; i < STAGES; i++) begin
                pipe_d[i] = pipe_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[LAST];

endmodule

// File: rtl/cmi_rx_decoder.sv
module cmi_rx_decoder
    import cmi_rx_pkg::*;
#(
    parameter int PIPE_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic hs_second,
    input  logic hs_data,
    output logic rx_data,
    output logic rx_viol
);

    logic     bit_stb;
    logic     first_half;
    bit_res_t sym_res;
    bit_res_t out_res;

    assign bit_stb = hs_en & hs_second;

    cmi_half_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_en      (hs_en),
        .hs_second  (hs_second),
        .hs_data    (hs_data),
        .first_half (first_half)
    );

    cmi_symbol_judge u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_stb     (bit_stb),
        .first_half  (first_half),
        .second_half (hs_data),
        .res         (sym_res)
    );

    cmi_bit_delay #(.STAGES(PIPE_BITS)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (bit_stb),
        .din   (sym_res),
        .dout  (out_res)
    );

    assign rx_data = out_res.data;
    assign rx_viol = out_res.viol;

endmodule

// File: rtl/cmi_rx_checker.sv
module cmi_rx_checker #(
    parameter int PIPE_BITS = 1
) (
    input logic clk,
    input logic rst_n,
    input logic hs_en,
    input logic hs_second,
    input logic hs_data,
    input logic rx_data,
    input logic rx_viol,
    input logic dec_data,
    input logic dec_viol
);

    logic shadow_first;
    logic stb;

    assign stb = hs_en && hs_second;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_first <= 1'b0;
        end else if (hs_en && !hs_second) begin
            shadow_first <= hs_data;
        end
    end

    // R7
    stable_outside_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(rx_data) && $stable(rx_viol)));

    // R2
    sym_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !shadow_first && hs_data) |=> (!dec_data && !dec_viol));

    // R3
    sym_high_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && shadow_first && !hs_data) |=> (!dec_data && dec_viol));

    // R4
    sym_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && (shadow_first == hs_data)) |=> dec_data);

    generate
        if (PIPE_BITS == 1) begin : g_one_stage
            // R8
            out_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stb |=> ((rx_data == $past(dec_data)) && (rx_viol == $past(dec_viol))));
        end
    endgenerate

endmodule

bind cmi_rx_decoder cmi_rx_checker #(.PIPE_BITS(PIPE_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_en     (hs_en),
    .hs_second (hs_second),
    .hs_data   (hs_data),
    .rx_data   (rx_data),
    .rx_viol   (rx_viol),
    .dec_data  (sym_res.data),
    .dec_viol  (sym_res.viol)
);

// File: tb/tb_cmi_rx_decoder.sv
module tb_cmi_rx_decoder;

    logic clk = 1'b0;
    logic rst_n;
    logic hs_en, hs_second, hs_data;
    logic rx_data, rx_viol;

    always #10 clk = ~clk;

    cmi_rx_decoder #(.PIPE_BITS(1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_en     (hs_en),
        .hs_second (hs_second),
        .hs_data   (hs_data),
        .rx_data   (rx_data),
        .rx_viol   (rx_viol)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic m_ref_v, m_ref_l;
    logic pend_d, pend_v;   // result of the last completed symbol
    logic held_d, held_v;   // value currently expected at the outputs

    task automatic chk(input string tag, input logic ed, input logic ev);
        checks++;
        if (rx_data !== ed || rx_viol !== ev) begin
            fails++;
            $display("FAIL %s: got data=%0b viol=%0b expected data=%0b viol=%0b",
                     tag, rx_data, rx_viol, ed, ev);
        end
    endtask

    task automatic model(input logic a, input logic b, output logic ed, output logic ev);
        if (a == 1'b0 && b == 1'b1) begin
            ed = 1'b0; ev = 1'b0;
        end else if (a == 1'b1 && b == 1'b0) begin
            ed = 1'b0; ev = 1'b1;
        end else begin
            ed = 1'b1;
            if (m_ref_v && m_ref_l == a) begin
                ev = 1'b1;
            end else begin
                ev = 1'b0;
                m_ref_v = 1'b1;
                m_ref_l = a;
            end
        end
    endtask

    task automatic strobe(input logic sec, input logic d, input int gap);
        repeat (gap) @(negedge clk);
        hs_en = 1'b1; hs_second = sec; hs_data = d;
        @(negedge clk);
        hs_en = 1'b0; hs_second = 1'b0; hs_data = $urandom_range(0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hs_en = 1'b0; hs_second = 1'b0; hs_data = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset held", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0);
        m_ref_v = 1'b0; m_ref_l = 1'b0;
        pend_d = 1'b0; pend_v = 1'b0;
        held_d = 1'b0; held_v = 1'b0;
    endtask

    task automatic send(input logic a, input logic b, input int gap, input string tag);
        logic cd, cv;
        model(a, b, cd, cv);
        strobe(1'b0, a, gap);
        chk("R7 first half no effect", held_d, held_v);
        strobe(1'b1, b, gap);
        chk({"R8 ", tag}, pend_d, pend_v);
        held_d = pend_d; held_v = pend_v;
        pend_d = cd; pend_v = cv;
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; hs_en = 1'b0; hs_second = 1'b0; hs_data = 1'b0;
        do_reset();

        // R6: first mark high accepted, R4 repeated high flagged
        send(1, 1, 0, "R6 first mark high");
        send(1, 1, 0, "R4 repeat high mark");
        // R5: flagged mark kept the reference at high, low accepted
        send(0, 0, 1, "R5 after flagged mark");
        send(0, 1, 0, "R2 low-high");
        send(0, 0, 2, "R4 repeat low mark");
        send(1, 0, 0, "R3 high-low");
        send(1, 1, 0, "R5 high after flagged low");
        send(0, 1, 3, "R9 gap between halves");
        send(0, 1, 0, "R8 flush");

        // R6: first mark low after a mid-stream reset
        do_reset();
        send(0, 0, 0, "R6 first mark low");
        send(1, 1, 1, "R4 alternating mark");
        send(0, 1, 0, "R8 flush");

        // Random stream
        for (int i = 0; i < 400; i++) begin
            send(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 2), "random R2 R3 R4 R9");
        end

        // R7: idle cycles keep the outputs
        repeat (5) @(negedge clk);
        chk("R7 idle no effect", held_d, held_v);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule